// File: doc/BRIEF.md
# Serial Bus Command Channel Engine

This block gives a host one command channel toward a serial peripheral bus. The host loads up to eight bytes of write data into two 32-bit data registers, then writes a packed command word. The engine decodes the opcode, slave id, register address and byte count, issues one request on a valid/ready bus port and waits for the response. The response carries a result code and up to eight read bytes.

When the transaction ends, a four-flag status register records completion and any error. Read data is placed in two read-data registers. A registered result code reports the outcome after the error flags have been ranked, so the host does not have to rank them itself. Only one transaction runs at a time. A bus that never answers is closed out by a cycle-count timeout.

Host registers, by byte offset: command 0x00, config 0x04 (reads zero, writes have no effect), status 0x08, write data 0x10/0x14, read data 0x18/0x1C. Register reads return on `host_rdata` one cycle after `host_addr` is presented.

Top module: `cmd_chan_engine`

## Requirements
- R1: After reset, status, both read-data registers and the result code (0) are zero, and `bus_req_valid` is low.
- R2: A data command word carries its opcode in bits [31:27], the slave id in [23:20], the register address in [19:4] and the byte count minus one in [2:0], with bit 26 clear. These fields appear unchanged on `bus_req_op`, `bus_req_sid`, `bus_req_addr` and `bus_req_len`. The write opcodes are 0, 2, 14 and 16. The read opcodes are 1, 13 and 15.
- R3: `bus_req_wdata` carries write-data word 0x10 in bits [31:0] (bytes 0-3) and word 0x14 in bits [63:32] (bytes 4-7), least significant byte first.
- R4: A read that completes with response code 0 loads bytes 0-3 into 0x18 and bytes 4-7 into 0x1C. Bytes beyond the byte count read as zero. Any other completion leaves both read-data registers unchanged.
- R5: Status bit 0 is DONE, bit 1 FAILURE, bit 2 DENIED and bit 3 DROPPED. Response code 0 gives 0x1, code 1 gives 0x3, code 2 gives 0x5, and code 3 gives 0x7.
- R6: `result` reads 0 while DONE is clear. Once DONE is set it reads 2 if DENIED is set, regardless of the other flags. Otherwise it reads 3 if FAILURE is set, otherwise 4 if DROPPED is set, and otherwise 1.
- R7: A command word with bit 26 set is a non-data command. It is valid when its opcode field equals k OR 0x08 for k in 3 to 6 (reset, sleep, shutdown, wakeup). It issues `bus_req_op` = k with the slave id, and with address and length driven to zero.
- R8: An unknown opcode, or a non-data command outside 3 to 6, issues no bus request and sets status to 0x3 at once.
- R9: A command write while a transaction is in flight is ignored: no new request is issued and the running transaction's fields are kept.
- R10: An accepted command write clears status to zero before the new transaction proceeds.
- R11: If the transaction is not finished within TIMEOUT_CYC cycles of the command write, the request is withdrawn and status becomes 0x9 (DONE and DROPPED).
- R12: `bus_req_valid` and its fields stay stable until `bus_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| busy | output | 1 | Transaction in flight |
| result | output | 3 | Ranked outcome: 0 pending, 1 ok, 2 denied, 3 failed, 4 dropped |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_op | output | 5 | Request opcode |
| bus_req_sid | output | 4 | Request slave id |
| bus_req_addr | output | 16 | Request register address |
| bus_req_len | output | 3 | Byte count minus one |
| bus_req_wdata | output | 64 | Write bytes 0-7 |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rsp_code | input | 2 | 0 ok, 1 failure, 2 denied, 3 denied and failure |
| bus_rsp_rdata | input | 64 | Read bytes 0-7 |

## Verification
The hardest condition to reach from the ports is a command write that lands while a transaction is waiting for its response. The bench holds the response back by ten cycles and writes a second command in that window. It then checks that exactly one request was seen and that this request carried the first command's fields. The timeout is reached by switching the bench responder to a mode that never raises ready. A following slow transaction is used to observe the cleared status while it is still in flight. Random transactions cover every opcode, length and response code against a model of the read-data registers.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  typedef enum logic [2:0] {
    RES_PEND    = 3'd0,
    RES_OK      = 3'd1,
    RES_DENIED  = 3'd2,
    RES_FAILED  = 3'd3,
    RES_DROPPED = 3'd4
  } result_e;

  typedef struct packed {
    logic        valid;
    logic        is_read;
    logic [4:0]  op;
    logic [3:0]  sid;
    logic [15:0] addr;
    logic [2:0]  len;
  } cmd_t;
endpackage

// File: rtl/cce_cmd_decode.sv
module cce_cmd_decode
  import cce_pkg::*;
(
  input  logic [31:0] word,
  output cmd_t        cmd
);
  logic [4:0] field;
  logic       nodata;
  logic       unused_bits;

  assign field       = word[31:27];
  assign nodata      = word[26];
  assign unused_bits = ^{word[25:24], word[3]};

  always_comb begin
    cmd         = '0;
    cmd.sid     = word[23:20];
    cmd.addr    = word[19:4];
    cmd.len     = word[2:0];
    if (nodata) begin
      cmd.op    = {2'b00, field[2:0]};
      cmd.addr  = '0;
      cmd.len   = '0;
      cmd.valid = (field[4:3] == 2'b01) && (field[2:0] >= 3'd3) && (field[2:0] <= 3'd6);
    end else begin
      cmd.op = field;
      case (field)
        5'd0, 5'd2, 5'd14, 5'd16: cmd.valid = 1'b1;
        5'd1, 5'd13, 5'd15: begin
          cmd.valid   = 1'b1;
          cmd.is_read = 1'b1;
        end
        default: cmd.valid = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cce_seq.sv
module cce_seq
  import cce_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int DATA_BYTES  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  cmd_t                      cmd,
  input  logic [DATA_BYTES*8-1:0]   wdata,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [4:0]                req_op,
  output logic [3:0]                req_sid,
  output logic [15:0]               req_addr,
  output logic [2:0]                req_len,
  output logic [DATA_BYTES*8-1:0]   req_wdata,
  input  logic                      rsp_valid,
  input  logic [1:0]                rsp_code,
  input  logic [DATA_BYTES*8-1:0]   rsp_rdata,
  output logic [3:0]                status,
  output logic [DATA_BYTES*8-1:0]   rdata,
  output logic                      busy
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;
  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             is_read;
  logic             expired;
  logic [DATA_BYTES*8-1:0] masked;

  assign busy    = (state != S_IDLE);
  assign expired = (cnt == CNT_LAST);

  always_comb begin
    for (int b = 0; b < DATA_BYTES; b++)
      masked[b*8 +: 8] = (b <= int'(req_len)) ? rsp_rdata[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      status    <= '0;
      rdata     <= '0;
      req_valid <= 1'b0;
      req_op    <= '0;
      req_sid   <= '0;
      req_addr  <= '0;
      req_len   <= '0;
      req_wdata <= '0;
      is_read   <= 1'b0;
      cnt       <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_we) begin
          cnt <= '0;
          if (cmd.valid) begin
            status    <= '0;
            req_valid <= 1'b1;
            req_op    <= cmd.op;
            req_sid   <= cmd.sid;
            req_addr  <= cmd.addr;
            req_len   <= cmd.len;
            req_wdata <= wdata;
            is_read   <= cmd.is_read;
            state     <= S_REQ;
          end else begin
            status <= 4'b0011;
          end
        end
        S_REQ: begin
          cnt <= cnt + 1'b1;
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= S_WAIT;
          end else if (expired) begin
            req_valid <= 1'b0;
            status    <= 4'b1001;
            state     <= S_IDLE;
          end
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (rsp_valid) begin
            status <= {1'b0, rsp_code[1], rsp_code[0], 1'b1};
            if (is_read && rsp_code == 2'd0) rdata <= masked;
            state <= S_IDLE;
          end else if (expired) begin
            status <= 4'b1001;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready && !expired |=> req_valid && $stable(req_op) && $stable(req_addr)
      && $stable(req_sid) && $stable(req_len)); // R12
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_we |=> $stable(req_op) && $stable(req_addr) && $stable(req_wdata)); // R9
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (|status[3:1]) |-> status[ST_DONE]); // R5
  AST_BUSY_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    busy |-> status == 4'b0000); // R10
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy); // R8
endmodule

// File: rtl/cce_outcome.sv
module cce_outcome
  import cce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] status,
  output result_e    result
);
  always_ff @(posedge clk) begin
    if (rst)                  result <= RES_PEND;
    else if (!status[ST_DONE]) result <= RES_PEND;
    else if (status[ST_DENY])  result <= RES_DENIED;
    else if (status[ST_FAIL])  result <= RES_FAILED;
    else if (status[ST_DROP])  result <= RES_DROPPED;
    else                       result <= RES_OK;
  end

  AST_DENY_WINS: assert property (@(posedge clk) disable iff (rst)
    status[ST_DONE] && status[ST_DENY] |=> result == RES_DENIED); // R6
  AST_PEND_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    !status[ST_DONE] |=> result == RES_PEND); // R6
endmodule

// File: rtl/cmd_chan_engine.sv
module cmd_chan_engine
  import cce_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic [2:0]  result,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [4:0]  bus_req_op,
  output logic [3:0]  bus_req_sid,
  output logic [15:0] bus_req_addr,
  output logic [2:0]  bus_req_len,
  output logic [63:0] bus_req_wdata,
  input  logic        bus_rsp_valid,
  input  logic [1:0]  bus_rsp_code,
  input  logic [63:0] bus_rsp_rdata
);
  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_STS = 5'h08,
                         A_WD0 = 5'h10, A_WD1 = 5'h14, A_RD0 = 5'h18, A_RD1 = 5'h1C;

  logic [31:0] cmd_q, wd0_q, wd1_q;
  logic        cmd_we;
  cmd_t        cmd;
  logic [3:0]  status;
  logic [63:0] rdata;
  result_e     res;

  assign cmd_we = host_we && (host_addr == A_CMD);
  assign result = res;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      wd0_q <= '0;
      wd1_q <= '0;
    end else if (host_we) begin
      if (host_addr == A_CMD && !busy) cmd_q <= host_wdata;
      if (host_addr == A_WD0)          wd0_q <= host_wdata;
      if (host_addr == A_WD1)          wd1_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_addr)
        A_CMD:   host_rdata <= cmd_q;
        A_CFG:   host_rdata <= '0;
        A_STS:   host_rdata <= {28'd0, status};
        A_WD0:   host_rdata <= wd0_q;
        A_WD1:   host_rdata <= wd1_q;
        A_RD0:   host_rdata <= rdata[31:0];
        A_RD1:   host_rdata <= rdata[63:32];
        default: host_rdata <= '0;
      endcase
    end
  end

  cce_cmd_decode u_dec (.word(host_wdata), .cmd(cmd));

  cce_seq #(.TIMEOUT_CYC(TIMEOUT_CYC), .DATA_BYTES(8)) u_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd(cmd), .wdata({wd1_q, wd0_q}),
    .req_valid(bus_req_valid), .req_ready(bus_req_ready), .req_op(bus_req_op),
    .req_sid(bus_req_sid), .req_addr(bus_req_addr), .req_len(bus_req_len),
    .req_wdata(bus_req_wdata), .rsp_valid(bus_rsp_valid), .rsp_code(bus_rsp_code),
    .rsp_rdata(bus_rsp_rdata), .status(status), .rdata(rdata), .busy(busy));

  cce_outcome u_out (.clk(clk), .rst(rst), .status(status), .result(res));
endmodule

// File: tb/sim_cmd_chan_engine.sv
module sim_cmd_chan_engine;
  logic        clk = 0, rst = 1;
  logic        host_we = 0;
  logic [4:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        busy, bus_req_valid, bus_req_ready = 0, bus_rsp_valid = 0;
  logic [2:0]  result, bus_req_len;
  logic [4:0]  bus_req_op;
  logic [3:0]  bus_req_sid;
  logic [15:0] bus_req_addr;
  logic [63:0] bus_req_wdata, bus_rsp_rdata = 0;
  logic [1:0]  bus_rsp_code = 0;

  int n_chk = 0, n_fail = 0;
  bit silent = 0;
  int rsp_delay = 1;
  logic [1:0]  cfg_code = 0;
  logic [63:0] cfg_data = 0;
  int req_count = 0, pend = 0;
  logic [4:0] c_op; logic [3:0] c_sid; logic [15:0] c_addr; logic [2:0] c_len; logic [63:0] c_wd;
  logic [63:0] rd_model = 0;

  always #5 clk = ~clk;

  cmd_chan_engine #(.TIMEOUT_CYC(16)) u0 (.*);

  initial begin
    forever begin
      @(negedge clk);
      bus_req_ready = 0;
      bus_rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          bus_rsp_valid = 1; bus_rsp_code = cfg_code; bus_rsp_rdata = cfg_data;
        end
      end else if (bus_req_valid && !silent) begin
        c_op = bus_req_op; c_sid = bus_req_sid; c_addr = bus_req_addr;
        c_len = bus_req_len; c_wd = bus_req_wdata;
        req_count++;
        bus_req_ready = 1;
        pend = rsp_delay;
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(5'h08, s);
      if (s[0]) break;
    end
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_status(logic [1:0] code);
    return {1'b0, code, 1'b1};
  endfunction

  function automatic logic [2:0] exp_result(logic [3:0] s);
    if (!s[0]) return 3'd0;
    if (s[2]) return 3'd2;
    if (s[1]) return 3'd3;
    if (s[3]) return 3'd4;
    return 3'd1;
  endfunction

  function automatic logic [63:0] mask_len(logic [63:0] d, logic [2:0] len);
    logic [63:0] m = 0;
    for (int b = 0; b < 8; b++) if (b <= int'(len)) m[b*8 +: 8] = d[b*8 +: 8];
    return m;
  endfunction

  function automatic logic [31:0] mk_cmd(logic [4:0] op, bit nd, logic [3:0] sid,
                                         logic [15:0] a, logic [2:0] len);
    return {op, nd, 2'b00, sid, a, 1'b0, len};
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    logic [4:0] ops [7] = '{5'd0, 5'd2, 5'd14, 5'd16, 5'd1, 5'd13, 5'd15};
    int cnt0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(5'h08, v); check("R1 status", v, 0);
    rd(5'h18, v); check("R1 rdata0", v, 0);
    rd(5'h1C, v); check("R1 rdata1", v, 0);
    rd(5'h04, v); check("R1 config", v, 0);
    check("R1 result", result, 0);
    check("R1 req_valid", bus_req_valid, 0);

    // R4 directed: read of 3 bytes masks upper bytes
    cfg_code = 0; cfg_data = 64'hFFFF_FFFF_FFFF_FFFF; rsp_delay = 2;
    wr(5'h00, mk_cmd(5'd15, 0, 4'h3, 16'h1234, 3'd2));
    wait_done();
    rd(5'h18, v); check("R4 masked rdata0", v, 32'h00FF_FFFF);
    rd(5'h1C, v); check("R4 masked rdata1", v, 0);
    rd_model = 64'h0000_0000_00FF_FFFF;

    // random transactions
    for (int it = 0; it < 40; it++) begin
      logic [4:0] op = ops[$urandom % 7];
      logic [3:0] sid = 4'($urandom);
      logic [15:0] ad = 16'($urandom);
      logic [2:0] ln = 3'($urandom);
      logic [31:0] w0 = $urandom, w1 = $urandom;
      logic [3:0] es;
      cfg_code = 2'($urandom); cfg_data = {$urandom, $urandom};
      rsp_delay = 1 + ($urandom % 5);
      wr(5'h10, w0); wr(5'h14, w1);
      wr(5'h00, mk_cmd(op, 0, sid, ad, ln));
      wait_done();
      check("R2 op", c_op, op); check("R2 sid", c_sid, sid);
      check("R2 addr", c_addr, ad); check("R2 len", c_len, ln);
      check("R3 wdata", c_wd, {w1, w0});
      es = exp_status(cfg_code);
      rd(5'h08, v); check("R5 status", v, es);
      check("R6 result", result, exp_result(es));
      if ((op == 1 || op == 13 || op == 15) && cfg_code == 0) rd_model = mask_len(cfg_data, ln);
      rd(5'h18, v); rd(5'h1C, v1); check("R4 rdata", {v1, v}, rd_model);
    end

    // R7 non-data command (sleep = 4)
    rsp_delay = 1; cfg_code = 0;
    wr(5'h00, mk_cmd(5'd12, 1, 4'h9, 16'hABCD, 3'd5));
    wait_done();
    check("R7 op", c_op, 4); check("R7 sid", c_sid, 9);
    check("R7 addr", c_addr, 0); check("R7 len", c_len, 0);

    // R8 invalid opcodes
    cnt0 = req_count;
    wr(5'h00, mk_cmd(5'd10, 1, 4'h1, 16'h0, 3'd0)); wait_done();
    rd(5'h08, v); check("R8 bad nodata status", v, 3);
    wr(5'h00, mk_cmd(5'd7, 0, 4'h1, 16'h0, 3'd0)); wait_done();
    rd(5'h08, v); check("R8 bad opcode status", v, 3);
    check("R6 failed result", result, 3);
    check("R8 no request", req_count, cnt0);

    // R11 timeout
    silent = 1;
    wr(5'h00, mk_cmd(5'd1, 0, 4'h2, 16'h0010, 3'd7));
    repeat (3) @(negedge clk);
    check("R12 valid held", bus_req_valid, 1);
    wait_done();
    rd(5'h08, v); check("R11 timeout status", v, 9);
    check("R6 dropped result", result, 4);
    check("R11 req withdrawn", bus_req_valid, 0);
    rd(5'h18, v); rd(5'h1C, v1); check("R4 rdata kept", {v1, v}, rd_model);
    silent = 0;

    // R10 status cleared, R9 command ignored while busy
    rsp_delay = 10; cfg_code = 2;
    cnt0 = req_count;
    wr(5'h00, mk_cmd(5'd14, 0, 4'h5, 16'h5555, 3'd1));
    rd(5'h08, v); check("R10 status cleared", v, 0);
    wr(5'h00, mk_cmd(5'd2, 0, 4'h6, 16'h6666, 3'd3));
    wait_done();
    check("R9 one request", req_count, cnt0 + 1);
    check("R9 first addr kept", c_addr, 16'h5555);
    rd(5'h08, v); check("R5 denied status", v, 5);
    check("R6 denied result", result, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule